// File: doc/BRIEF.md
# Pipelined Feedback-Free Delta-Sigma Modulator

This block turns a stream of unsigned multi-bit samples, one per clock, into a noise-shaped code stream, one code per clock. A first-order build gives a single bit. A build of order N gives a small signed code. The quantiser has no loop around it. The input is summed through N cascaded modular accumulators. Only the top bits of the last accumulator are kept as the coarse value. That value is then passed through N cascaded first-difference stages. Every stage is a register, so no adder path is longer than one accumulator.

Each output code is the one an error-feedback quantiser of the same order would give for the same input, delayed by a fixed number of steps. A downstream switch and low-pass filter average the codes back to the input level. A zero-insertion mode slows the modulator to one step every two clocks and places a zero code on the idle clocks. This halves the average output level.

Top module: `pipe_dsm`

## Requirements
- R1: With ORDER=1, y is one unsigned bit. Number the modulator steps k = 0, 1, 2, … from reset. The bit after step k equals the carry of an error-feedback quantiser fed the input of step k-3. That quantiser forms s = x + e, outputs s >> DW and keeps e = s mod 2^DW, with e = 0 and a zero output before the first input.
- R2: With ORDER=N>1, y is a two's-complement code of N+1 bits. The code after step k equals floor(v / 2^DW) for the input of step k-2N-1. Here v = x + Σ_{j=1..N} (-1)^(j+1)·C(N,j)·e_j, e_j is the residue j samples back, and the new residue is v minus the code times 2^DW. All residues start at zero.
- R3: For ORDER=N>1, the signed value of y always lies between -(2^(N-1)) and 2^(N-1), both included.
- R4: With a constant input x, the mean of the output codes over a long run equals x / 2^DW.
- R5: The accumulators wrap modulo their width and never saturate. The full-scale input 2^DW-1 still meets R1, R2 and R4.
- R6: While pad_en is high, the modulator takes a step on alternate clocks only, and y is zero on every other clock. The first clock with pad_en high is a step clock. The average output is then half of x / 2^DW per clock.
- R7: While pad_en is high, the value on x during a non-step clock has no effect on any output.
- R8: While rst_n is low, y is zero and all state is cleared. The first clock edge after release is step 0.
- R9: The first clock with pad_en low is a step clock, and every clock is a step clock while it stays low. The output sequence continues with no gap or repeated step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_en | input | 1 | Zero-insertion mode: step on alternate clocks, zero code between steps |
| x | input | DW | Unsigned input sample, taken on step clocks |
| y | output | ORDER==1 ? 1 : ORDER+1 | Output code: one bit for order 1, otherwise two's complement |

## Verification
Three builds (orders 1, 2 and 3) run side by side. Each is compared on every clock against an integer error-feedback model of its own order. The closed-loop form cannot hide a wrong accumulator count or a wrong sign in the difference chain. Constant inputs at quarter scale, near zero and full scale separate correct modular wrap from saturation, and their long-run means expose a biased quantiser. Random samples with zero insertion switched on and off at odd times show whether steps are skipped or repeated, and whether a sample offered on an idle clock leaks in. A reset in mid-run checks that every pipeline stage starts clean.

// File: rtl/pipe_dsm_pkg.sv
package pipe_dsm_pkg;

  // Width of the quantised code: one bit for order 1, N+1 bits otherwise.
  function automatic int dsm_out_width(input int order);
    return (order == 1) ? 1 : order + 1;
  endfunction

endpackage

// File: rtl/dsm_integ_chain.sv
// Cascade of modular accumulators, one register per stage.
module dsm_integ_chain #(
  parameter int DW    = 16,
  parameter int ORDER = 2,
  parameter int QW    = 3,
  localparam int AW   = DW + QW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] x,
  output logic [AW-1:0] acc_last
);

  logic [ORDER:0][AW-1:0]   feed;
  logic [ORDER-1:0][AW-1:0] acc_q, acc_d;

  always_comb begin
    feed[0] = {{QW{1'b0}}, x};
    for (int k = 0; k < ORDER; k++) feed[k+1] = acc_q[k];
  end

  // Sum wraps at AW bits; the carry out is dropped.
  always_comb begin
    for (int k = 0; k < ORDER; k++)
      acc_d[k] = en ? acc_q[k] + feed[k] : acc_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_last = acc_q[ORDER-1];

endmodule

// File: rtl/dsm_quant.sv
// Coarse quantiser: registers only the top QW bits of the last accumulator.
module dsm_quant #(
  parameter int AW = 19,
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] acc,
  output logic [QW-1:0] q
);

  logic [QW-1:0] q_d;

  always_comb q_d = en ? acc[AW-1 -: QW] : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/dsm_diff_chain.sv
// Cascade of first-difference stages; order 1 collapses to an XOR.
module dsm_diff_chain #(
  parameter int ORDER = 2,
  parameter int QW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [QW-1:0] q,
  output logic [QW-1:0] d_out
);

  if (ORDER == 1) begin : g_xor
    logic q_prev, q_prev_d, d_q, d_d;

    always_comb begin
      q_prev_d = en ? q[0] : q_prev;
      d_d      = en ? (q[0] ^ q_prev) : d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_prev <= 1'b0;
        d_q    <= 1'b0;
      end else begin
        q_prev <= q_prev_d;
        d_q    <= d_d;
      end
    end

    assign d_out = d_q;
  end else begin : g_sub
    logic [ORDER:0][QW-1:0]   link;
    logic [ORDER-1:0][QW-1:0] prev_q, prev_d, d_q, d_d;

    always_comb begin
      link[0] = q;
      for (int k = 0; k < ORDER; k++) link[k+1] = d_q[k];
    end

    // Differences wrap at QW bits; the true value always fits signed QW.
    always_comb begin
      for (int k = 0; k < ORDER; k++) begin
        prev_d[k] = en ? link[k] : prev_q[k];
        d_d[k]    = en ? link[k] - prev_q[k] : d_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        d_q    <= '0;
      end else begin
        prev_q <= prev_d;
        d_q    <= d_d;
      end
    end

    assign d_out = d_q[ORDER-1];
  end

endmodule

// File: rtl/dsm_pad.sv
// Step pacing and zero insertion at the output register.
module dsm_pad #(
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad_en,
  input  logic [OW-1:0] d_in,
  output logic          adv,
  output logic [OW-1:0] y
);

  logic          ph_q, ph_d;
  logic [OW-1:0] y_d;

  always_comb begin
    adv  = ~pad_en | ~ph_q;
    ph_d = pad_en ? ~ph_q : 1'b0;
    y_d  = adv ? d_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      y    <= '0;
    end else begin
      ph_q <= ph_d;
      y    <= y_d;
    end
  end

endmodule

// File: rtl/pipe_dsm.sv
module pipe_dsm
  import pipe_dsm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ORDER = 2,
  localparam int OW   = dsm_out_width(ORDER),
  localparam int AW   = DW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad_en,
  input  logic [DW-1:0] x,
  output logic [OW-1:0] y
);

  logic          adv;
  logic [AW-1:0] acc_last;
  logic [OW-1:0] q;
  logic [OW-1:0] d_last;

  dsm_integ_chain #(.DW(DW), .ORDER(ORDER), .QW(OW)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(adv), .x(x), .acc_last(acc_last)
  );

  dsm_quant #(.AW(AW), .QW(OW)) u_quant (
    .clk(clk), .rst_n(rst_n), .en(adv), .acc(acc_last), .q(q)
  );

  dsm_diff_chain #(.ORDER(ORDER), .QW(OW)) u_diff (
    .clk(clk), .rst_n(rst_n), .en(adv), .q(q), .d_out(d_last)
  );

  dsm_pad #(.OW(OW)) u_pad (
    .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .d_in(d_last),
    .adv(adv), .y(y)
  );

endmodule

// File: rtl/pipe_dsm_chk.sv
module pipe_dsm_chk #(
  parameter int ORDER = 2,
  parameter int OW    = 3,
  parameter int AW    = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pad_en,
  input logic          adv,
  input logic [OW-1:0] y,
  input logic [AW-1:0] acc_last
);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pad_en) && $past(pad_en, 2)) |-> (y == '0 || $past(y) == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc_last));

  // R9
  resume_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pad_en) |-> adv);

  if (ORDER > 1) begin : g_rng
    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(y) >= -(2 ** (ORDER - 1))) && ($signed(y) <= 2 ** (ORDER - 1)));
  end

endmodule

bind pipe_dsm pipe_dsm_chk #(.ORDER(ORDER), .OW(OW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .adv(adv), .y(y),
  .acc_last(acc_last)
);

// File: tb/sim_pipe_dsm.sv
module sim_pipe_dsm;
  localparam int DW = 8;
  localparam int M  = 1 << DW;

  logic clk;
  logic rst_n, pad_en;
  logic [DW-1:0] x;
  logic [0:0] y1;
  logic [2:0] y2;
  logic [3:0] y3;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pipe_dsm #(.DW(DW), .ORDER(1)) u0 (.clk(clk), .rst_n(rst_n), .pad_en(pad_en), .x(x), .y(y1));
  pipe_dsm #(.DW(DW), .ORDER(2)) u1 (.clk(clk), .rst_n(rst_n), .pad_en(pad_en), .x(x), .y(y2));
  pipe_dsm #(.DW(DW), .ORDER(3)) u2 (.clk(clk), .rst_n(rst_n), .pad_en(pad_en), .x(x), .y(y3));

  int     n_cmp, n_bad;
  bit     ph_m;
  int     step;
  int     yq[3][$];
  longint eh[3][3];
  longint sum[3];
  int     win_clk;
  string  sec;
  int     seed;

  function automatic int binom(int n, int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  // Closed-loop error-feedback model of order o+1
  task automatic ref_step(input int o, input int xv, output int yv);
    longint v, e, yl;
    int n = o + 1;
    v = xv;
    for (int j = 1; j <= n; j++)
      v += ((j % 2) ? 1 : -1) * binom(n, j) * eh[o][j-1];
    if (v >= 0) yl = v / M;
    else        yl = -((-v + M - 1) / M);
    e = v - yl * M;
    for (int j = 2; j >= 1; j--) eh[o][j] = eh[o][j-1];
    eh[o][0] = e;
    yv = int'(yl);
  endtask

  function automatic int dut_y(int o);
    case (o)
      0:       return int'(y1);
      1:       return int'($signed(y2));
      default: return int'($signed(y3));
    endcase
  endfunction

  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int o = 0; o < 3; o++) begin
      yq[o].delete();
      for (int j = 0; j < 3; j++) eh[o][j] = 0;
    end
    step = 0;
    ph_m = 1'b0;
  endtask

  task automatic win_clear();
    for (int o = 0; o < 3; o++) sum[o] = 0;
    win_clk = 0;
  endtask

  task automatic cycle(input bit pad, input int xv);
    int exp[3];
    int yv, a, lat;
    bit adv_m;
    string t;
    pad_en = pad;
    x      = xv[DW-1:0];
    adv_m  = !pad || !ph_m;
    for (int o = 0; o < 3; o++) exp[o] = 0;
    if (adv_m) begin
      for (int o = 0; o < 3; o++) begin
        ref_step(o, xv, yv);
        yq[o].push_back(yv);
        lat = 2 * (o + 1) + 1;
        if (step - lat >= 0) exp[o] = yq[o][step - lat];
      end
      step++;
    end
    ph_m = pad ? !ph_m : 1'b0;
    @(negedge clk);
    for (int o = 0; o < 3; o++) begin
      a = dut_y(o);
      if (sec == "R1") t = (o == 0) ? "R1" : "R2";
      else             t = sec;
      chk(t, a, exp[o]);
      sum[o] += a;
      if (o > 0) chk("R3", ((a >= -(1 << o)) && (a <= (1 << o))) ? 1 : 0, 1);
    end
    win_clk++;
  endtask

  task automatic mean_chk(string r, int xv, bit pad);
    longint lhs, rhs, d;
    for (int o = 0; o < 3; o++) begin
      lhs = sum[o] * M * (pad ? 2 : 1);
      rhs = longint'(xv) * win_clk;
      d   = lhs - rhs;
      if (d < 0) d = -d;
      n_cmp++;
      if (d > 16 * M) begin
        n_bad++;
        $display("FAIL %s: order%0d code sum actual %0d expected %0d", r, o + 1,
                 sum[o], rhs / (M * (pad ? 2 : 1)));
      end
    end
  endtask

  task automatic dc_run(string r, int xv);
    sec = r;
    repeat (40) cycle(1'b0, xv);
    win_clear();
    repeat (512) cycle(1'b0, xv);
    mean_chk("R4", xv, 1'b0);
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & (M - 1);
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; seed = 7;
    rst_n = 1'b0; pad_en = 1'b0; x = '0;
    model_reset();
    win_clear();
    repeat (3) @(negedge clk);
    // R8: outputs cleared in reset
    chk("R8", int'(y1), 0);
    chk("R8", int'($signed(y2)), 0);
    chk("R8", int'($signed(y3)), 0);
    rst_n = 1'b1;

    dc_run("R1", 64);
    dc_run("R1", 200);
    dc_run("R5", M - 1);     // full scale, accumulators must wrap
    dc_run("R1", 1);

    sec = "R1";
    repeat (2000) cycle(1'b0, rnd());

    // R6: zero insertion halves the mean
    sec = "R6";
    cycle(1'b0, 128);
    repeat (40) cycle(1'b1, 128);
    win_clear();
    repeat (512) cycle(1'b1, 128);
    mean_chk("R6", 128, 1'b1);

    // R7: inputs on idle clocks must not leak in
    sec = "R7";
    repeat (1000) cycle(1'b1, rnd());

    // R9: leaving and re-entering zero insertion at odd times
    sec = "R9";
    repeat (300) cycle(1'b0, rnd());
    for (int i = 0; i < 600; i++) cycle(((i / 7) % 2) == 1, rnd());
    for (int i = 0; i < 300; i++) cycle(((i / 3) % 2) == 0, rnd());

    // R8: reset in mid-run, then fresh start
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", int'(y1), 0);
    chk("R8", int'($signed(y2)), 0);
    chk("R8", int'($signed(y3)), 0);
    rst_n = 1'b1;
    model_reset();
    sec = "R8";
    repeat (300) cycle(1'b0, rnd());

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule